// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block holds the configuration settings of nine logical devices and lets a host reach all of them through only two byte addresses in I/O space. The host first writes a register number into an index pointer at the lower address. It then reads or writes the selected register through a data window at the next address up. A strap pin picks which address pair the block answers to. The strap is captured while reset is asserted and then held.

Index values below 30h select registers shared by all devices. One of these is a device-select register that chooses which device's bank the upper index values reach. Each bank holds an activate bit, a 16-bit I/O base, an IRQ number and a DMA channel. These fields leave the block as registered, flattened buses for the functional blocks.

The host side uses plain one-cycle read and write strobes with no back-pressure. Every access completes in the cycle it is presented. Read data is combinational from the strobe and the address.

Top module: `cfg_index_port`

## Requirements
- R1: The block claims a cycle (io_claim=1) only when io_rd or io_wr is high and the full 16-bit io_addr equals base or base+1. Base is 002Eh when the latched strap is 0 and 004Eh when it is 1.
- R2: strap_sel is captured at every rising clock edge while rst_n is low. Changes of strap_sel while rst_n is high do not change the decoded pair.
- R3: The index pointer at base is 8 bits wide, reads back the last value written to it, and is 00h after reset.
- R4: An access at base+1 reaches the register named by the index. Index 00h–2Fh selects the shared registers. Index 30h–FFh selects the bank of the device chosen in the device-select register.
- R5: Shared register 07h is device select. A written value 0–8 is stored, a written value above 8 leaves the stored value unchanged, and a read returns the stored value. It is 0 after reset.
- R6: The bank registers are:
  - 30h: bit 0 is activate.
  - 60h: I/O base bits 15:8.
  - 61h: I/O base bits 7:0.
  - 70h: bits 3:0 hold the IRQ number.
  - 74h: bits 2:0 hold the DMA channel.

  Unused bits read 0, and all fields are 0 after reset.
- R7: Reads of any other index value return 00h. Writes to any other index value change no register and no output.
- R8: When a cycle is not claimed, io_rdata is 00h and a write has no effect.
- R9: A write takes effect at the rising edge where io_wr is sampled high. Device outputs change only at the edge that follows a cycle with io_wr high.
- R10: Device d drives the following bus slices:
  - dev_active[d] with its activate bit.
  - dev_iobase[16d+15:16d] with its I/O base.
  - dev_irq[4d+3:4d] with its IRQ number.
  - dev_dma[3d+2:3d] with its DMA channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; strap is sampled while low |
| strap_sel | input | 1 | Address-pair select strap |
| io_addr | input | 16 | Host I/O address |
| io_rd | input | 1 | Host read strobe |
| io_wr | input | 1 | Host write strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, 00h when not claimed |
| io_claim | output | 1 | Cycle decoded by this block |
| dev_active | output | 9 | Activate bit per device |
| dev_iobase | output | 144 | 16-bit I/O base per device |
| dev_irq | output | 36 | 4-bit IRQ number per device |
| dev_dma | output | 27 | 3-bit DMA channel per device |

## Verification
A single write strobe at base+1 with index 07h can both store a new device select and change which bank later writes land in. The same strobe with a value above 8 must leave the previous bank in force. The bench interleaves device-select writes, including out-of-range values, with writes to the bank fields. It judges each bank by reading it back and by checking the flattened outputs against a model kept in the bench. A second collision comes from moving the strap while the block is running, in the same period as host accesses at both address pairs. The bench requires the old pair to keep answering and the other pair to stay silent.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam logic [7:0] IDX_DEVSEL    = 8'h07;
  localparam logic [7:0] IDX_BANK_LO   = 8'h30;
  localparam logic [7:0] IDX_ACTIVATE  = 8'h30;
  localparam logic [7:0] IDX_IOBASE_HI = 8'h60;
  localparam logic [7:0] IDX_IOBASE_LO = 8'h61;
  localparam logic [7:0] IDX_IRQ       = 8'h70;
  localparam logic [7:0] IDX_DMA       = 8'h74;

  localparam int IOBASE_W = 16;
  localparam int IRQ_W    = 4;
  localparam int DMA_W    = 3;

  typedef struct packed {
    logic                activate;
    logic [IOBASE_W-1:0] iobase;
    logic [IRQ_W-1:0]    irq;
    logic [DMA_W-1:0]    dma;
  } dev_cfg_t;
endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode #(
  parameter logic [15:0] BASE_A = 16'h002E,
  parameter logic [15:0] BASE_B = 16'h004E
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strap_sel,
  input  logic [15:0] io_addr,
  input  logic        io_rd,
  input  logic        io_wr,
  output logic        strap_lat,
  output logic        sel_index,
  output logic        sel_data
);
  localparam logic [15:0] DATA_A = BASE_A + 16'd1;
  localparam logic [15:0] DATA_B = BASE_B + 16'd1;

  logic        strap_q;
  logic [15:0] idx_addr;
  logic [15:0] dat_addr;
  logic        strobe;

  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_sel;
  end

  always_comb begin
    idx_addr  = strap_q ? BASE_B : BASE_A;
    dat_addr  = strap_q ? DATA_B : DATA_A;
    strobe    = io_rd | io_wr;
    sel_index = strobe && (io_addr == idx_addr);
    sel_data  = strobe && (io_addr == dat_addr);
  end

  assign strap_lat = strap_q;
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs #(
  parameter int NUM_DEV = 9,
  localparam int SEL_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_we,
  input  logic             dat_we,
  input  logic [7:0]       wdata,
  output logic [7:0]       idx_q,
  output logic [SEL_W-1:0] devsel_q,
  output logic [7:0]       glb_rdata
);
  import cfg_pkg::*;
  localparam logic [7:0] NDEV8 = 8'(NUM_DEV);

  logic sel_ok;

  assign sel_ok = (wdata < NDEV8);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= 8'h00;
      devsel_q <= '0;
    end else begin
      if (idx_we) idx_q <= wdata;
      if (dat_we && idx_q == IDX_DEVSEL && sel_ok)
        devsel_q <= wdata[SEL_W-1:0];
    end
  end

  always_comb begin
    glb_rdata = 8'h00;
    if (idx_q == IDX_DEVSEL) glb_rdata = 8'(devsel_q);
  end
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [7:0]        idx,
  input  logic [7:0]        wdata,
  output cfg_pkg::dev_cfg_t cfg,
  output logic [7:0]        rdata
);
  import cfg_pkg::*;

  dev_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (we) begin
      case (idx)
        IDX_ACTIVATE:  cfg_q.activate      <= wdata[0];
        IDX_IOBASE_HI: cfg_q.iobase[15:8]  <= wdata;
        IDX_IOBASE_LO: cfg_q.iobase[7:0]   <= wdata;
        IDX_IRQ:       cfg_q.irq           <= wdata[IRQ_W-1:0];
        IDX_DMA:       cfg_q.dma           <= wdata[DMA_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      IDX_ACTIVATE:  rdata = {7'd0, cfg_q.activate};
      IDX_IOBASE_HI: rdata = cfg_q.iobase[15:8];
      IDX_IOBASE_LO: rdata = cfg_q.iobase[7:0];
      IDX_IRQ:       rdata = 8'(cfg_q.irq);
      IDX_DMA:       rdata = 8'(cfg_q.dma);
      default:       rdata = 8'h00;
    endcase
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port #(
  parameter int          NUM_DEV = 9,
  parameter logic [15:0] BASE_A  = 16'h002E,
  parameter logic [15:0] BASE_B  = 16'h004E
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strap_sel,
  input  logic [15:0]          io_addr,
  input  logic                 io_rd,
  input  logic                 io_wr,
  input  logic [7:0]           io_wdata,
  output logic [7:0]           io_rdata,
  output logic                 io_claim,
  output logic [NUM_DEV-1:0]   dev_active,
  output logic [NUM_DEV*16-1:0] dev_iobase,
  output logic [NUM_DEV*4-1:0] dev_irq,
  output logic [NUM_DEV*3-1:0] dev_dma
);
  import cfg_pkg::*;
  localparam int SEL_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic             strap_lat;
  logic             sel_index;
  logic             sel_data;
  logic [7:0]       idx_q;
  logic [SEL_W-1:0] devsel_q;
  logic [7:0]       glb_rdata;
  logic             in_bank;
  logic [7:0]       bank_rdata;
  logic [7:0]       bank_rd [NUM_DEV];
  dev_cfg_t         bank_cfg [NUM_DEV];

  cfg_addr_decode #(.BASE_A(BASE_A), .BASE_B(BASE_B)) u_dec (
    .clk(clk), .rst_n(rst_n), .strap_sel(strap_sel), .io_addr(io_addr),
    .io_rd(io_rd), .io_wr(io_wr), .strap_lat(strap_lat),
    .sel_index(sel_index), .sel_data(sel_data)
  );

  cfg_global_regs #(.NUM_DEV(NUM_DEV)) u_glb (
    .clk(clk), .rst_n(rst_n),
    .idx_we(io_wr && sel_index),
    .dat_we(io_wr && sel_data && !in_bank),
    .wdata(io_wdata), .idx_q(idx_q), .devsel_q(devsel_q),
    .glb_rdata(glb_rdata)
  );

  assign in_bank = (idx_q >= IDX_BANK_LO);

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_bank
    cfg_dev_bank u_bank (
      .clk(clk), .rst_n(rst_n),
      .we(io_wr && sel_data && in_bank && (devsel_q == SEL_W'(d))),
      .idx(idx_q), .wdata(io_wdata),
      .cfg(bank_cfg[d]), .rdata(bank_rd[d])
    );
    assign dev_active[d]         = bank_cfg[d].activate;
    assign dev_iobase[16*d +: 16] = bank_cfg[d].iobase;
    assign dev_irq[4*d +: 4]     = bank_cfg[d].irq;
    assign dev_dma[3*d +: 3]     = bank_cfg[d].dma;
  end

  always_comb begin
    bank_rdata = 8'h00;
    for (int d = 0; d < NUM_DEV; d++)
      if (devsel_q == SEL_W'(d)) bank_rdata = bank_rd[d];
  end

  always_comb begin
    io_claim = sel_index | sel_data;
    io_rdata = 8'h00;
    if (io_rd && sel_index)     io_rdata = idx_q;
    else if (io_rd && sel_data) io_rdata = in_bank ? bank_rdata : glb_rdata;
  end
endmodule

// File: rtl/cfg_index_port_chk.sv
module cfg_index_port_chk #(
  parameter int          NUM_DEV = 9,
  parameter logic [15:0] BASE_A  = 16'h002E,
  parameter logic [15:0] BASE_B  = 16'h004E,
  localparam int SEL_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [15:0]           io_addr,
  input logic                  io_rd,
  input logic                  io_wr,
  input logic [7:0]            io_wdata,
  input logic [7:0]            io_rdata,
  input logic                  io_claim,
  input logic [NUM_DEV*16-1:0] dev_iobase,
  input logic [NUM_DEV*4-1:0]  dev_irq,
  input logic [NUM_DEV*3-1:0]  dev_dma,
  input logic [NUM_DEV-1:0]    dev_active,
  input logic                  strap_lat,
  input logic [7:0]            idx_q,
  input logic [SEL_W-1:0]      devsel_q
);
  AST_CLAIM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    io_claim |-> (io_addr == BASE_A || io_addr == BASE_A + 16'd1 ||
                  io_addr == BASE_B || io_addr == BASE_B + 16'd1)); // R1

  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(strap_lat)); // R2

  AST_IDX_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(io_wr) && $past(io_claim) && !$past(io_addr[0]) &&
     $past(io_addr[15:1]) == (strap_lat ? BASE_B[15:1] : BASE_A[15:1]))
    |-> idx_q == $past(io_wdata)); // R3

  AST_DEVSEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(devsel_q) < NUM_DEV); // R5

  AST_UNCLAIMED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !io_claim |-> io_rdata == 8'h00); // R8

  AST_CLAIM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    io_claim |-> (io_rd || io_wr)); // R8

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(io_wr)) |->
    ($stable(dev_iobase) && $stable(dev_irq) &&
     $stable(dev_dma) && $stable(dev_active))); // R9
endmodule

bind cfg_index_port cfg_index_port_chk #(
  .NUM_DEV(NUM_DEV), .BASE_A(BASE_A), .BASE_B(BASE_B)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .io_claim(io_claim),
  .dev_iobase(dev_iobase), .dev_irq(dev_irq), .dev_dma(dev_dma),
  .dev_active(dev_active), .strap_lat(strap_lat), .idx_q(idx_q),
  .devsel_q(devsel_q)
);

// File: tb/cfg_index_port_tb.sv
`timescale 1ns/100ps
module cfg_index_port_tb;
  localparam int ND = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_sel = 1'b0;
  logic [15:0] io_addr = '0;
  logic io_rd = 1'b0;
  logic io_wr = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic io_claim;
  logic [ND-1:0] dev_active;
  logic [ND*16-1:0] dev_iobase;
  logic [ND*4-1:0] dev_irq;
  logic [ND*3-1:0] dev_dma;

  int n_chk = 0;
  int n_fail = 0;

  logic [15:0] m_base [ND];
  logic [3:0]  m_irq [ND];
  logic [2:0]  m_dma [ND];
  logic        m_act [ND];
  int          m_sel;

  always #2.5 clk = ~clk;

  cfg_index_port u_dut (
    .clk(clk), .rst_n(rst_n), .strap_sel(strap_sel), .io_addr(io_addr),
    .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_claim(io_claim), .dev_active(dev_active), .dev_iobase(dev_iobase),
    .dev_irq(dev_irq), .dev_dma(dev_dma)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 1'b0; strap_sel = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int d = 0; d < ND; d++) begin
      m_base[d] = 0; m_irq[d] = 0; m_dma[d] = 0; m_act[d] = 0;
    end
    m_sel = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] v);
    @(negedge clk);
    io_addr = a; io_wdata = v; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v, output logic c);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1;
    v = io_rdata; c = io_claim;
    io_rd = 1'b0;
  endtask

  task automatic reg_wr(input logic [15:0] b, input logic [7:0] i, input logic [7:0] v);
    wr(b, i); wr(b + 16'd1, v);
  endtask

  task automatic reg_rd(input logic [15:0] b, input logic [7:0] i, output logic [7:0] v);
    logic c;
    wr(b, i); rd(b + 16'd1, v, c);
  endtask

  task automatic chk_outputs(input string req);
    for (int d = 0; d < ND; d++) begin
      chk(req, 32'(dev_iobase[16*d +: 16]), 32'(m_base[d]));
      chk(req, 32'(dev_irq[4*d +: 4]), 32'(m_irq[d]));
      chk(req, 32'(dev_dma[3*d +: 3]), 32'(m_dma[d]));
      chk(req, 32'(dev_active[d]), 32'(m_act[d]));
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic c;
    logic [15:0] b;

    // Reset with strap 0: pair 2Eh/2Fh
    do_reset(1'b0);
    b = 16'h002E;
    rd(b, v, c); chk("R3 reset index", v, 8'h00); chk("R1 claim index", c, 1);
    chk_outputs("R6 reset outputs");
    reg_rd(b, 8'h07, v); chk("R5 reset devsel", v, 8'h00);

    // R3: index read-back of every value
    for (int i = 0; i < 256; i++) begin
      wr(b, 8'(i)); rd(b, v, c); chk("R3 index readback", v, 32'(i));
    end

    // R1/R8: full address sweep with index 5Ah (unimplemented bank register)
    wr(b, 8'h5A);
    for (int a = 0; a < 65536; a++) begin
      rd(16'(a), v, c);
      chk("R1 claim sweep", c, (a == 16'h2E || a == 16'h2F) ? 1 : 0);
      chk("R8 rdata sweep", v, (a == 16'h2E) ? 8'h5A : 8'h00);
    end
    // R8: idle bus, claimed address without strobe
    @(negedge clk); io_addr = b; #1;
    chk("R8 no strobe claim", io_claim, 0); chk("R8 no strobe rdata", io_rdata, 0);

    // R5: device select, values above 8 ignored
    for (int s = 0; s < 16; s++) begin
      reg_wr(b, 8'h07, 8'(s));
      if (s < ND) m_sel = s;
      reg_rd(b, 8'h07, v); chk("R5 devsel readback", v, 32'(m_sel));
    end

    // R4/R6/R9/R10: configure each device, interleaved with bad device selects
    for (int d = 0; d < ND; d++) begin
      reg_wr(b, 8'h07, 8'(d));
      reg_wr(b, 8'h07, 8'(9 + d));
      m_base[d] = 16'(16'h1000 * (d + 1) + 16'h0011 * d + 16'h0008);
      m_irq[d]  = 4'(d + 3);
      m_dma[d]  = 3'(d);
      m_act[d]  = d[0];
      reg_wr(b, 8'h60, m_base[d][15:8]);
      reg_wr(b, 8'h61, m_base[d][7:0]);
      reg_wr(b, 8'h70, 8'hF0 | 8'(m_irq[d]));
      reg_wr(b, 8'h74, 8'hF8 | 8'(m_dma[d]));
      // R9: an activate write changes the output only after its strobe edge
      @(negedge clk); io_addr = b + 16'd1; io_wdata = 8'hFE;
      wr(b, 8'h30);
      @(negedge clk); io_addr = b + 16'd1; io_wdata = {7'h7F, m_act[d]}; io_wr = 1'b1;
      #1; chk("R9 before edge", dev_active[d], 0);
      @(negedge clk); io_wr = 1'b0;
      chk("R9 after edge", dev_active[d], m_act[d]);
    end
    chk_outputs("R10 outputs");

    // R4/R6: read back each bank through device select
    for (int d = 0; d < ND; d++) begin
      reg_wr(b, 8'h07, 8'(d));
      reg_rd(b, 8'h60, v); chk("R4 iobase hi", v, 32'(m_base[d][15:8]));
      reg_rd(b, 8'h61, v); chk("R4 iobase lo", v, 32'(m_base[d][7:0]));
      reg_rd(b, 8'h70, v); chk("R6 irq", v, 32'(m_irq[d]));
      reg_rd(b, 8'h74, v); chk("R6 dma", v, 32'(m_dma[d]));
      reg_rd(b, 8'h30, v); chk("R6 activate", v, 32'(m_act[d]));
    end

    // R7: unimplemented index values
    reg_wr(b, 8'h07, 8'd4);
    for (int i = 0; i < 256; i++) begin
      if (i == 8'h07 || i == 8'h30 || i == 8'h60 || i == 8'h61 ||
          i == 8'h70 || i == 8'h74) continue;
      reg_wr(b, 8'(i), 8'hA5);
      reg_rd(b, 8'(i), v); chk("R7 unimpl read", v, 8'h00);
    end
    reg_rd(b, 8'h07, v); chk("R7 devsel kept", v, 8'h04);
    chk_outputs("R7 outputs kept");

    // R8: writes to unclaimed addresses have no effect
    wr(b, 8'h61);
    wr(16'h004F, 8'h77); wr(16'h102F, 8'h77); wr(16'h002D, 8'h33);
    rd(b, v, c); chk("R8 index kept", v, 8'h61);
    chk_outputs("R8 outputs kept");

    // R2: strap change while running is ignored
    strap_sel = 1'b1;
    repeat (4) @(negedge clk);
    wr(b, 8'h3C);
    rd(b, v, c); chk("R2 old pair claimed", c, 1); chk("R2 old pair index", v, 8'h3C);
    rd(16'h004E, v, c); chk("R2 new pair silent", c, 0); chk("R2 new pair rdata", v, 0);

    // R1/R2: reset with strap 1 selects 4Eh/4Fh, config cleared
    do_reset(1'b1);
    strap_sel = 1'b0;
    b = 16'h004E;
    for (int a = 0; a < 256; a++) begin
      rd(16'(a), v, c);
      chk("R1 strap1 claim", c, (a == 16'h4E || a == 16'h4F) ? 1 : 0);
    end
    rd(b, v, c); chk("R3 index after reset", v, 8'h00);
    chk_outputs("R6 cleared by reset");
    reg_wr(b, 8'h07, 8'd8); m_sel = 8;
    reg_wr(b, 8'h70, 8'h0C); m_irq[8] = 4'hC;
    reg_rd(b, 8'h70, v); chk("R4 strap1 data window", v, 8'h0C);
    chk_outputs("R10 strap1 outputs");

    summary();
    $finish;
  end
endmodule